// File: doc/BRIEF.md
# DMA Channel Event Flag Register

This block keeps the sticky interrupt status of a multi-channel DMA controller. Each channel engine reports three kinds of event as one-cycle pulses: a transfer error, reaching the halfway point of a transfer, and completing a transfer. Each pulse sets a sticky flag. A fourth flag per channel summarises the other three and drives that channel's interrupt line.

Software reads all flags through a status word. It acknowledges events by writing ones into a separate clear word, which is write-one-to-clear. Each channel has one clear bit that wipes every flag of that channel at once. The bus is a simple single-cycle register port. The status word and the clear word share one per-channel nibble layout. Read data is combinational.

Top module: `dma_irq_flags`

## Requirements
- R1: While reset is asserted, every flag is 0, every irq output is 0 and the status word reads 0.
- R2: An event pulse on ev_err, ev_half or ev_done for channel c at a rising edge sets the matching flag. The flag is visible in the status word (word address 0) from that edge on and stays set until cleared. Channel c owns bits 4c+3..4c: bit 4c is global, 4c+1 is complete, 4c+2 is half, 4c+3 is error.
- R3: A channel's global bit is 1 exactly when at least one of its error, half or complete flags is 1. irq[c] equals that global bit.
- R4: Writing 1 to the complete, half or error bit of a channel in the clear word (word address 1) clears only that flag. Clear bits written as 0 leave their flags unchanged.
- R5: Writing 1 to a channel's global clear bit (bit 4c of the clear word) clears that channel's error, half, complete and global flags together.
- R6: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: Reading the clear word returns 0. Status bits above the last channel (bits 31:28 by default) read 0, and writing ones there has no effect.
- R8: A write to the status word changes no flag.
- R9: A write to the clear word acts only on byte lanes whose bus_be bit is 1. Ones in disabled lanes clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Word address: 0 status, 1 clear |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ev_err | input | 7 | Per-channel transfer error pulse |
| ev_half | input | 7 | Per-channel half-transfer pulse |
| ev_done | input | 7 | Per-channel transfer complete pulse |
| irq | output | 7 | Per-channel interrupt request |

## Verification
The bench builds the block with its default parameters: seven channels on a 32-bit data word. With these values the status word has one unused nibble at the top, so the reserved-bit behaviour can be observed. Several channels also share a single byte lane, which lets the byte-enable masking be tested. One channel's nibble sits in the top byte lane, next to the reserved nibble, and the set-over-clear race can be set up on error, half and complete flags in different lanes.

// File: rtl/dmaflag_pkg.sv
package dmaflag_pkg;
   // per-channel nibble layout, shared by status and clear words
   localparam int FLAGS_PER_CH = 4;
   localparam int IDX_GLB  = 0;
   localparam int IDX_DONE = 1;
   localparam int IDX_HALF = 2;
   localparam int IDX_ERR  = 3;
   // word addresses
   localparam logic WORD_STS = 1'b0;
   localparam logic WORD_CLR = 1'b1;
endpackage

// File: rtl/dmaflag_lane_clr.sv
module dmaflag_lane_clr #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  logic              wr_clr,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] clr_vec
);
   // each byte lane forwards its write ones only when enabled
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign clr_vec[8*l +: 8] = (wr_clr && be[l]) ? wdata[8*l +: 8] : 8'h00;
   end
endmodule

// File: rtl/dmaflag_chan.sv
module dmaflag_chan
   import dmaflag_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ev_err,
   input  logic                    ev_half,
   input  logic                    ev_done,
   input  logic [FLAGS_PER_CH-1:0] clr,
   output logic [FLAGS_PER_CH-1:0] nib
);
   logic err_q, half_q, done_q;
   logic clr_all;

   assign clr_all = clr[IDX_GLB];

   // set dominates clear so that no event is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         half_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         err_q  <= ev_err  | (err_q  & ~(clr[IDX_ERR]  | clr_all));
         half_q <= ev_half | (half_q & ~(clr[IDX_HALF] | clr_all));
         done_q <= ev_done | (done_q & ~(clr[IDX_DONE] | clr_all));
      end
   end

   always_comb begin
      nib           = '0;
      nib[IDX_ERR]  = err_q;
      nib[IDX_HALF] = half_q;
      nib[IDX_DONE] = done_q;
      nib[IDX_GLB]  = err_q | half_q | done_q;
   end

   AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err |=> nib[IDX_ERR]); // R6
   AST_HALF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_half |=> nib[IDX_HALF]); // R6
   AST_ERR_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_err && !nib[IDX_ERR]) |=> !nib[IDX_ERR]); // R2
   AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[IDX_DONE] && !ev_done) |=> !nib[IDX_DONE]); // R4
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (nib[IDX_DONE] && !clr[IDX_DONE] && !clr_all) |=> nib[IDX_DONE]); // R4
   AST_GLB_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !ev_err && !ev_half && !ev_done) |=> (nib == '0)); // R5
endmodule

// File: rtl/dmaflag_rdmux.sv
module dmaflag_rdmux
   import dmaflag_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int DATA_W = 32,
   localparam int USED_W = NUM_CH * FLAGS_PER_CH
) (
   input  logic              rd_en,
   input  logic              word,
   input  logic [USED_W-1:0] flags,
   output logic [DATA_W-1:0] sts_word,
   output logic [DATA_W-1:0] rdata
);
   // pad unused upper status bits with zero
   if (USED_W < DATA_W) begin : g_pad
      assign sts_word = {{(DATA_W-USED_W){1'b0}}, flags};
   end else begin : g_full
      assign sts_word = flags;
   end

   // clear word is write-only and reads back as zero
   assign rdata = (rd_en && word == WORD_STS) ? sts_word : '0;

   always_comb begin
      AST_CLR_READS_ZERO: assert (!(rd_en && word == WORD_CLR) || rdata == '0); // R7
   end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
   import dmaflag_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int USED_W = NUM_CH * FLAGS_PER_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [LANES-1:0]  bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] ev_err,
   input  logic [NUM_CH-1:0] ev_half,
   input  logic [NUM_CH-1:0] ev_done,
   output logic [NUM_CH-1:0] irq
);
   if (NUM_CH < 1) begin : g_chk_ch
      $error("NUM_CH must be at least 1");
   end
   if (DATA_W % 8 != 0) begin : g_chk_bytes
      $error("DATA_W must be a whole number of bytes");
   end
   if (USED_W > DATA_W) begin : g_chk_fit
      $error("channel flags do not fit the data word");
   end

   logic              wr_clr;
   logic              rd_en;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] sts_word;
   logic [USED_W-1:0] flags;

   assign wr_clr = bus_sel && bus_we && (bus_addr == WORD_CLR);
   assign rd_en  = bus_sel && !bus_we;

   dmaflag_lane_clr #(.DATA_W(DATA_W)) u_lane (
      .wr_clr (wr_clr),
      .be     (bus_be),
      .wdata  (bus_wdata),
      .clr_vec(clr_vec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmaflag_chan u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .ev_err (ev_err[c]),
         .ev_half(ev_half[c]),
         .ev_done(ev_done[c]),
         .clr    (clr_vec[FLAGS_PER_CH*c +: FLAGS_PER_CH]),
         .nib    (flags[FLAGS_PER_CH*c +: FLAGS_PER_CH])
      );
      assign irq[c] = flags[FLAGS_PER_CH*c + IDX_GLB];
   end

   if (USED_W < DATA_W) begin : g_rsvd
      logic unused_rsvd_clr;
      assign unused_rsvd_clr = |clr_vec[DATA_W-1:USED_W];
   end

   dmaflag_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
      .rd_en   (rd_en),
      .word    (bus_addr),
      .flags   (flags),
      .sts_word(sts_word),
      .rdata   (bus_rdata)
   );

   AST_STS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == WORD_STS && ev_err == '0 && ev_half == '0
       && ev_done == '0) |=> $stable(sts_word)); // R8
   AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && ev_err == '0 && ev_half == '0 && ev_done == '0)
      |=> $stable(sts_word)); // R2
   AST_IRQ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_err == '0 && ev_half == '0 && ev_done == '0 && irq == '0)
      |=> irq == '0); // R3
endmodule

// File: tb/dma_irq_flags_test.sv
module dma_irq_flags_test;
   localparam int NCH = 7;
   localparam int VW  = 91;
   localparam int NV  = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
   logic [3:0]  bus_be = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] ev_err = '0, ev_half = '0, ev_done = '0;
   logic [NCH-1:0] irq;

   int n_chk = 0, n_fail = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   dma_irq_flags uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ev_err(ev_err), .ev_half(ev_half),
      .ev_done(ev_done), .irq(irq)
   );

   // {err, half, done, we, addr, be, wdata, expected status after the edge}
   localparam logic [VW-1:0] VECS [NV] = '{
      {7'h00, 7'h00, 7'h01, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0000_0003}, // R2 done ch0
      {7'h40, 7'h02, 7'h00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0900_0053}, // R2 R3
      {7'h00, 7'h00, 7'h00, 1'b1, 1'b1, 4'hF, 32'h0000_0002, 32'h0900_0050}, // R4
      {7'h00, 7'h00, 7'h00, 1'b1, 1'b0, 4'hF, 32'hFFFF_FFFF, 32'h0900_0050}, // R8
      {7'h00, 7'h00, 7'h00, 1'b1, 1'b1, 4'h1, 32'h0F00_0010, 32'h0900_0000}, // R9 R5
      {7'h00, 7'h00, 7'h40, 1'b1, 1'b1, 4'hF, 32'h0800_0000, 32'h0300_0000}, // R4
      {7'h08, 7'h00, 7'h00, 1'b1, 1'b1, 4'hF, 32'h0000_1000, 32'h0300_9000}, // R6
      {7'h00, 7'h00, 7'h00, 1'b1, 1'b1, 4'hF, 32'hF100_0000, 32'h0000_9000}, // R5 R7
      {7'h00, 7'h00, 7'h00, 1'b1, 1'b1, 4'hF, 32'h0000_0000, 32'h0000_9000}, // R4 zeros
      {7'h00, 7'h00, 7'h00, 1'b1, 1'b1, 4'h2, 32'h0000_1000, 32'h0000_0000}, // R9 R5
      {7'h00, 7'h04, 7'h00, 1'b1, 1'b1, 4'h2, 32'h0000_0400, 32'h0000_0500}  // R6
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] irq_of(input logic [31:0] s);
      logic [31:0] r = '0;
      for (int c = 0; c < NCH; c++) r[c] = |s[4*c +: 4];
      return r;
   endfunction

   task automatic go_idle_read(input logic a);
      ev_err = '0; ev_half = '0; ev_done = '0;
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'h0; bus_wdata = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      go_idle_read(1'b0);
      #1;
      chk("R1 status in reset", bus_rdata, 32'h0);
      chk("R1 irq in reset", {25'h0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VECS[i];
         @(negedge clk);
         ev_err = v[90:84]; ev_half = v[83:77]; ev_done = v[76:70];
         bus_sel = v[69]; bus_we = v[69]; bus_addr = v[68];
         bus_be = v[67:64]; bus_wdata = v[63:32];
         @(negedge clk);
         go_idle_read(1'b0);
         #1;
         chk($sformatf("R2/R4/R5/R6 vector %0d status", i), bus_rdata, v[31:0]);
         chk($sformatf("R3 vector %0d irq", i), {25'h0, irq}, irq_of(v[31:0]));
      end

      // clear word reads zero while flags are set
      go_idle_read(1'b1);
      #1;
      chk("R7 clear word reads zero", bus_rdata, 32'h0);

      // every event on every channel; reserved nibble stays zero
      @(negedge clk);
      ev_err = '1; ev_half = '1; ev_done = '1; bus_sel = 1'b0;
      @(negedge clk);
      go_idle_read(1'b0);
      #1;
      chk("R7 reserved bits zero", bus_rdata, 32'h0FFF_FFFF);
      chk("R3 all irq", {25'h0, irq}, 32'h7F);

      // writes to status do not disturb anything
      @(negedge clk);
      bus_we = 1'b1; bus_be = 4'hF; bus_wdata = 32'h0;
      @(negedge clk);
      go_idle_read(1'b0);
      #1;
      chk("R8 status write of zeros", bus_rdata, 32'h0FFF_FFFF);

      // reset mid-run wipes everything
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk("R1 reset clears", bus_rdata, 32'h0);
      chk("R1 reset irq", {25'h0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule